// File: doc/BRIEF.md
# Multi-Mode Operand Fetch and Add Unit

This unit carries out one kind of operation: add a second operand to a destination register and write the sum back to that register. The second operand is located in one of six ways. It can be the command's 16-bit constant. It can be another register. It can be a memory word addressed by a register, by the constant, or by the constant plus a register. It can also be a memory word whose address is itself read from memory at a register's address. The unit holds an eight-entry register file of 16-bit words. It forms the effective address internally and issues at most one read at a time to a single-port data memory.

Commands arrive on a valid/ready port. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that edge until the writeback cycle has passed, so a sender must hold its next command until then. Memory reads leave on a valid/ready request channel. Once a request is raised, its address stays fixed until it is accepted. The response returns on `mem_rsp_valid` with no back-pressure, and the unit is always ready for it because only one read is ever in flight. `done` marks the writeback cycle, and `wb_reg`/`wb_data` show the register written and its new value. `illegal` flags a rejected mode code.

Top module: `mfa_unit`

## Requirements
- R1: After reset, `cmd_ready` is high, `done`, `illegal` and `mem_req_valid` are low, and all eight registers hold zero.
- R2: Mode code 0 (immediate) writes Rd + constant. `done` rises in the cycle right after acceptance, and no memory read is issued.
- R3: Mode code 1 (register) writes Rd + Rs without reading memory. When Rd equals Rs, the register doubles.
- R4: Mode code 2 (register indirect) issues one read at the address held in Rs and writes Rd + the returned word.
- R5: Mode code 3 (direct) issues one read at the constant and writes Rd + the returned word.
- R6: Mode code 4 (memory indirect) issues a read at the value of Rs. It then issues a second read at the word the first read returned, and writes Rd + the word from the second read.
- R7: Mode code 5 (displacement) issues one read at constant + Rs, with that sum taken modulo 2^16, and writes Rd + the returned word.
- R8: No new read request appears between a request's acceptance and its `mem_rsp_valid` response.
- R9: A request that is not accepted stays raised with an unchanged address on the next cycle.
- R10: `done` is high for exactly one cycle, the writeback cycle. In that cycle `wb_reg` is Rd and `wb_data` is the new value, and sums wrap modulo 2^16.
- R11: Mode codes 6 and 7 pulse `illegal` for one cycle, in the cycle after acceptance. No read is issued, `done` does not pulse, and no register changes.
- R12: `cmd_ready` is low from acceptance of a legal command until the cycle after `done`. A command held on the port during that time is neither taken nor executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_mode | input | 3 | Operand mode code |
| cmd_rd | input | 3 | Destination register index |
| cmd_rs | input | 3 | Source register index |
| cmd_const | input | 16 | Constant, absolute address or displacement |
| mem_req_valid | output | 1 | Read request raised |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 16 | Read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 16 | Returned word |
| done | output | 1 | Writeback cycle |
| wb_reg | output | 3 | Register written |
| wb_data | output | 16 | Value written |
| illegal | output | 1 | Rejected mode code |

## Verification
The bench targets memory-indirect mode. A unit that chained the reads wrongly would issue the second read at the register value or add the pointer word instead of the final word, and a wrong address or sum shows this. Displacement and repeated doubling are run near 0xFFFF, where an adder that does not wrap would give the wrong result. The memory model varies its latency and stalls its ready signal: a unit that moved on without waiting for the response, or changed the address during a stall, is caught by the address and hold checks. Illegal codes are followed by a zero-constant read-back, and a junk command is held on the port while the unit is busy; a unit that wrote on a rejected code or took the held command would change a register the bench later reads back.

// File: rtl/mfa_pkg.sv
package mfa_pkg;

  typedef enum logic [2:0] {
    MD_IMM  = 3'd0,
    MD_REG  = 3'd1,
    MD_RIND = 3'd2,
    MD_DIR  = 3'd3,
    MD_MIND = 3'd4,
    MD_DISP = 3'd5,
    MD_BAD6 = 3'd6,
    MD_BAD7 = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_WB   = 2'd3
  } state_e;

  function automatic logic mode_legal(mode_e m);
    return (m != MD_BAD6) && (m != MD_BAD7);
  endfunction

  function automatic logic mode_reads_mem(mode_e m);
    return (m == MD_RIND) || (m == MD_DIR) || (m == MD_MIND) || (m == MD_DISP);
  endfunction

endpackage

// File: rtl/mfa_regfile.sv
module mfa_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] idx_a,
  output logic [DW-1:0] val_a,
  input  logic [RW-1:0] idx_b,
  output logic [DW-1:0] val_b,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata
);

  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         regs[g] <= '0;
      else if (we && (waddr == RW'(g)))   regs[g] <= wdata;
    end
  end

  assign val_a = regs[idx_a];
  assign val_b = regs[idx_b];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (regs[$past(waddr)] == $past(wdata))); // R10

endmodule

// File: rtl/mfa_agen.sv
module mfa_agen
  import mfa_pkg::*;
#(
  parameter int DW = 16
) (
  input  mode_e         mode,
  input  logic [DW-1:0] rs_val,
  input  logic [DW-1:0] konst,
  output logic [DW-1:0] ea
);

  always_comb begin
    unique case (mode)
      MD_DIR:  ea = konst;
      MD_DISP: ea = konst + rs_val;
      default: ea = rs_val;
    endcase
  end

endmodule

// File: rtl/mfa_ctrl.sv
module mfa_ctrl
  import mfa_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cmd_valid,
  input  mode_e cmd_mode,
  output logic  cmd_ready,
  output logic  accept,
  output mode_e mode_q,
  output logic  mem_req_valid,
  input  logic  mem_req_ready,
  input  logic  mem_rsp_valid,
  output logic  rsp_take,
  output logic  use_ptr,
  output logic  done,
  output logic  illegal
);

  state_e state;
  logic   second_q;
  logic   illegal_q;

  assign cmd_ready     = (state == ST_IDLE);
  assign accept        = cmd_valid && cmd_ready;
  assign mem_req_valid = (state == ST_REQ);
  assign rsp_take      = (state == ST_WAIT) && mem_rsp_valid;
  assign use_ptr       = second_q;
  assign done          = (state == ST_WB);
  assign illegal       = illegal_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      second_q  <= 1'b0;
      illegal_q <= 1'b0;
      mode_q    <= MD_IMM;
    end else begin
      illegal_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          mode_q <= cmd_mode;
          if (!mode_legal(cmd_mode)) begin
            illegal_q <= 1'b1;
          end else if (mode_reads_mem(cmd_mode)) begin
            second_q <= 1'b0;
            state    <= ST_REQ;
          end else begin
            state <= ST_WB;
          end
        end
        ST_REQ: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if ((mode_q == MD_MIND) && !second_q) begin
            second_q <= 1'b1;
            state    <= ST_REQ;
          end else begin
            state <= ST_WB;
          end
        end
        ST_WB: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && !mem_req_valid)); // R11

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_legal(cmd_mode)) |=> !cmd_ready); // R12

endmodule

// File: rtl/mfa_unit.sv
module mfa_unit
  import mfa_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_mode,
  input  logic [RW-1:0] cmd_rd,
  input  logic [RW-1:0] cmd_rs,
  input  logic [DW-1:0] cmd_const,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [DW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          done,
  output logic [RW-1:0] wb_reg,
  output logic [DW-1:0] wb_data,
  output logic          illegal
);

  logic          accept, rsp_take, use_ptr;
  mode_e         mode_q;
  logic [RW-1:0] rd_q, rs_q;
  logic [DW-1:0] k_q, data_q;
  logic [DW-1:0] rd_val, rs_val, ea, operand;

  mfa_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_mode      (mode_e'(cmd_mode)),
    .cmd_ready     (cmd_ready),
    .accept        (accept),
    .mode_q        (mode_q),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_take      (rsp_take),
    .use_ptr       (use_ptr),
    .done          (done),
    .illegal       (illegal)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      rs_q   <= '0;
      k_q    <= '0;
      data_q <= '0;
    end else begin
      if (accept) begin
        rd_q <= cmd_rd;
        rs_q <= cmd_rs;
        k_q  <= cmd_const;
      end
      if (rsp_take) data_q <= mem_rsp_data;
    end
  end

  mfa_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .idx_a (rd_q),
    .val_a (rd_val),
    .idx_b (rs_q),
    .val_b (rs_val),
    .we    (done),
    .waddr (rd_q),
    .wdata (wb_data)
  );

  mfa_agen #(.DW(DW)) u_agen (
    .mode   (mode_q),
    .rs_val (rs_val),
    .konst  (k_q),
    .ea     (ea)
  );

  assign mem_req_addr = use_ptr ? data_q : ea;

  always_comb begin
    unique case (mode_q)
      MD_IMM:  operand = k_q;
      MD_REG:  operand = rs_val;
      default: operand = data_q;
    endcase
  end

  assign wb_data = rd_val + operand;
  assign wb_reg  = rd_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R8

endmodule

// File: tb/mfa_unit_tb_top.sv
`timescale 1ns/1ps
module mfa_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_mode = '0;
  logic [2:0]  cmd_rd = '0;
  logic [2:0]  cmd_rs = '0;
  logic [15:0] cmd_const = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        done;
  logic [2:0]  wb_reg;
  logic [15:0] wb_data;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  logic [15:0] ref_rf [8];
  logic [15:0] exp_addr [$];

  always #2.5 clk = ~clk;

  mfa_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mode(cmd_mode),
    .cmd_rd(cmd_rd), .cmd_rs(cmd_rs), .cmd_const(cmd_const),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .wb_reg(wb_reg),
    .wb_data(wb_data), .illegal(illegal)
  );

  function automatic logic [15:0] memf(input logic [15:0] a);
    logic [31:0] p;
    p = a * 32'd40503 + 32'd4660;
    return p[15:0] ^ 16'h0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Memory model: varies ready stalls and response latency.
  initial begin
    bit          pending = 0;
    int          cnt = 0;
    int          nreq = 0;
    logic [15:0] cap = '0;
    bit          stalled = 0;
    logic [15:0] stall_addr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (stalled) begin
        chk(mem_req_valid && (mem_req_addr == stall_addr), "R9", "request held during stall",
            {15'd0, mem_req_valid}, 32'd1);
        stalled = 0;
      end
      if (pending) begin
        mem_req_ready = 1'b0;
        if (mem_req_valid) chk(0, "R8", "request while read outstanding", 1, 0);
        cnt--;
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = memf(cap);
          pending = 0;
        end
      end else begin
        mem_req_ready = ((nreq + cnt) % 4) != 1;
        cnt++;
        if (mem_req_valid && mem_req_ready) begin
          if (exp_addr.size() == 0) begin
            chk(0, "R11", "unexpected memory read", {16'd0, mem_req_addr}, 0);
          end else begin
            logic [15:0] e;
            e = exp_addr.pop_front();
            chk(mem_req_addr == e, "R6", "read address", {16'd0, mem_req_addr}, {16'd0, e});
          end
          cap = mem_req_addr;
          pending = 1;
          nreq++;
          cnt = 1 + (nreq % 3);
        end else if (mem_req_valid) begin
          stalled = 1;
          stall_addr = mem_req_addr;
        end
      end
    end
  end

  task automatic do_cmd(input int md, input int rd, input int rs,
                        input logic [15:0] k, input string req, input bit junk);
    logic [15:0] rv, opnd, expv;
    int cyc;
    rv = ref_rf[rs];
    case (md)
      0: opnd = k;
      1: opnd = rv;
      2: begin exp_addr.push_back(rv); opnd = memf(rv); end
      3: begin exp_addr.push_back(k); opnd = memf(k); end
      4: begin exp_addr.push_back(rv); exp_addr.push_back(memf(rv)); opnd = memf(memf(rv)); end
      5: begin exp_addr.push_back(k + rv); opnd = memf(k + rv); end
      default: opnd = '0;
    endcase
    expv = ref_rf[rd] + opnd;
    @(negedge clk);
    cmd_mode = md[2:0]; cmd_rd = rd[2:0]; cmd_rs = rs[2:0]; cmd_const = k; cmd_valid = 1'b1;
    chk(cmd_ready, req, "ready before command", {31'd0, cmd_ready}, 1);
    @(negedge clk);
    if (junk) begin
      cmd_mode = 3'd0; cmd_rd = 3'd7; cmd_rs = 3'd0; cmd_const = 16'h00AA;
    end else begin
      cmd_valid = 1'b0;
    end
    if (md >= 6) begin
      chk(illegal && !done, "R11", "illegal pulse after accept", {31'd0, illegal}, 1);
      @(negedge clk);
      chk(!illegal && !done && cmd_ready, "R11", "illegal one cycle, no done", {31'd0, illegal}, 0);
      chk(exp_addr.size() == 0, "R11", "no read for illegal", exp_addr.size(), 0);
      cmd_valid = 1'b0;
      return;
    end
    cyc = 0;
    while (!done && cyc < 60) begin
      chk(!cmd_ready, "R12", "ready low while busy", {31'd0, cmd_ready}, 0);
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0;
    chk(done, "R10", "done seen", {31'd0, done}, 1);
    chk(!cmd_ready, "R12", "ready low in writeback", {31'd0, cmd_ready}, 0);
    chk(wb_reg == rd[2:0], "R10", "wb_reg", {29'd0, wb_reg}, rd);
    chk(wb_data == expv, req, "sum written", {16'd0, wb_data}, {16'd0, expv});
    if (md <= 1) begin
      chk(cyc == 0, "R2", "done one cycle after accept", cyc, 0);
      chk(!mem_req_valid, "R3", "no memory read for register/immediate", {31'd0, mem_req_valid}, 0);
    end
    chk(exp_addr.size() == 0, req, "all expected reads issued", exp_addr.size(), 0);
    ref_rf[rd] = expv;
    @(negedge clk);
    chk(!done && cmd_ready, "R10", "done one cycle wide", {31'd0, done}, 0);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) ref_rf[i] = '0;
    repeat (3) @(negedge clk);
    chk(cmd_ready && !done && !illegal && !mem_req_valid, "R1", "outputs in reset",
        {28'd0, cmd_ready, done, illegal, mem_req_valid}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !done && !illegal && !mem_req_valid, "R1", "outputs after reset",
        {28'd0, cmd_ready, done, illegal, mem_req_valid}, 32'h8);
    for (int i = 0; i < 8; i++) do_cmd(0, i, 0, 16'h0000, "R1", 0);

    do_cmd(0, 1, 0, 16'hFFFF, "R2", 0);
    do_cmd(0, 1, 0, 16'h0002, "R10", 0);
    do_cmd(0, 0, 0, 16'h1234, "R2", 0);
    do_cmd(0, 2, 0, 16'h0010, "R2", 0);
    do_cmd(0, 4, 0, 16'h00A0, "R2", 0);
    do_cmd(0, 5, 0, 16'hFFF0, "R2", 0);

    do_cmd(1, 0, 2, 16'h9999, "R3", 0);
    do_cmd(1, 2, 2, 16'h0000, "R3", 0);
    do_cmd(1, 5, 5, 16'h0000, "R3", 0);

    do_cmd(2, 4, 2, 16'h0000, "R4", 0);
    do_cmd(3, 5, 0, 16'h0777, "R5", 0);
    do_cmd(4, 6, 4, 16'h0000, "R6", 0);
    do_cmd(5, 0, 5, 16'hFFF8, "R7", 0);

    do_cmd(6, 0, 1, 16'h5555, "R11", 0);
    do_cmd(7, 3, 2, 16'h6666, "R11", 0);
    do_cmd(0, 0, 0, 16'h0000, "R11", 0);
    do_cmd(0, 3, 0, 16'h0000, "R11", 0);

    do_cmd(4, 1, 6, 16'h0000, "R6", 1);
    do_cmd(0, 7, 0, 16'h0000, "R12", 0);

    for (int i = 0; i < 24; i++) begin
      int md;
      md = i % 6;
      do_cmd(md, (i * 3) % 8, (i * 5 + 1) % 8, 16'(i * 16'h1357 + 16'hFF00),
             (md == 0) ? "R2" : (md == 1) ? "R3" : (md == 2) ? "R4" :
             (md == 3) ? "R5" : (md == 4) ? "R6" : "R7", 0);
    end
    for (int i = 0; i < 8; i++) do_cmd(0, i, 0, 16'h0000, "R10", 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule